// File: doc/BRIEF.md
# Configuration Shadow Mismatch Monitor

This block protects a small bank of configuration registers against random bit upsets. Every configuration word sits next to a shadow word that must always equal its bitwise inverse. While the device runs, the monitor keeps comparing every pair. If any pair stops being an exact inverse, the monitor raises a reset request for a fixed number of cycles. It also clears a sticky, active-low event flag that tells software why the device restarted.

The bank is filled through a load port, which the restart sequencer drives with values read from nonvolatile storage. While `ld_busy` is high the compare is masked, so a half-written pair does not cause a false request. After power-on, after a warm reset from any other source, and after a mismatch reset, the monitor stays disarmed until a full reload has completed. A warm reset never touches the event flag. Software sets the flag back to 1 by writing a 1 through the status write port. A fault-injection port flips one chosen bit of a chosen word, so a self-test can confirm that a reset follows.

Top module: `cfgshd_monitor`

## Requirements
- R1: After a reload in which each shadow word is written as the bitwise inverse of its register, `rst_req` stays low for as long as the bank is left untouched.
- R2: A single-bit flip injected into a configuration register while armed makes `rst_req` go high in the second cycle after the injection edge.
- R3: A single-bit flip injected into a shadow word while armed triggers the same request, with the same timing as R2.
- R4: Each mismatch request holds `rst_req` high for exactly PULSE_CYC consecutive cycles (4 by default) and then drops it.
- R5: `flag_n` goes to 0 in the same cycle that `rst_req` rises for a mismatch.
- R6: A status write with `sw_wdata`=1 sets `flag_n` to 1 and a write with `sw_wdata`=0 has no effect. A mismatch event in the same cycle wins, and the flag ends at 0.
- R7: `warm_rst` never changes `flag_n`. It aborts any request and leaves the monitor disarmed until the next reload.
- R8: While `ld_busy` is high the compare is masked, so a pair broken during a load raises no request.
- R9: After power-on, a warm reset or a mismatch reset, mismatches raise no request until `ld_busy` has been seen high and then low again.
- R10: After power-on reset, `rst_req` is 0 and `flag_n` is 1.
- R11: A load-port write made while `ld_busy` is low that breaks a pair counts as a mismatch, with R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| warm_rst | input | 1 | Reset from any other source, synchronous, active high |
| ld_busy | input | 1 | High for the whole duration of a reload |
| ld_we | input | 1 | Load-port write strobe |
| ld_to_shadow | input | 1 | 1 writes the shadow word, 0 writes the configuration register |
| ld_idx | input | IDX_W | Pair index of the load-port write |
| ld_data | input | REG_W | Load-port write data |
| inj_en | input | 1 | Fault-injection strobe, flips one bit (the load port wins on a clash) |
| inj_to_shadow | input | 1 | 1 flips a bit of the shadow word, 0 a bit of the register |
| inj_idx | input | IDX_W | Pair index for the flip, must be below NUM_REGS |
| inj_bit | input | BIT_W | Bit position for the flip |
| sw_wr | input | 1 | Status write strobe |
| sw_wdata | input | 1 | Status write value; 1 sets the flag, 0 is ignored |
| rst_req | output | 1 | Reset request pulse |
| flag_n | output | 1 | Sticky active-low mismatch event flag |

## Verification
The bench builds the monitor with its default parameters: four pairs of 16-bit words and a 4-cycle request. With these values every request pulse can be watched from start to end within a few cycles, and a flip can be placed at the first and last pair and at the top and bottom bit. A behavioural model checks both outputs every cycle. Directed checks cover arming after reload, masking during a load, warm resets with the flag at either value, and a status set that lands in the same cycle as a mismatch event.

// File: rtl/cfgshd_pkg.sv
package cfgshd_pkg;

  // Monitor sequencing: armed and comparing, pulsing a request,
  // waiting for a reload to start, and riding out the reload.
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LOAD  = 2'd3
  } mon_state_e;

endpackage

// File: rtl/cfgshd_rst_sync.sv
module cfgshd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  // Assert at once, release only after STAGES clean clock edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfgshd_bank.sv
module cfgshd_bank #(
  parameter int  NUM_REGS = 4,
  parameter int  REG_W    = 16,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int BIT_W    = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we_i,
  input  logic             ld_to_shadow_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [REG_W-1:0] ld_data_i,
  input  logic             inj_en_i,
  input  logic             inj_to_shadow_i,
  input  logic [IDX_W-1:0] inj_idx_i,
  input  logic [BIT_W-1:0] inj_bit_i,
  output logic             mismatch_o
);

  logic [REG_W-1:0]    flip_mask;
  logic [NUM_REGS-1:0] pair_bad;

  assign flip_mask = {{(REG_W-1){1'b0}}, 1'b1} << inj_bit_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_pair
    logic [REG_W-1:0] val_q, val_d, shd_q, shd_d;
    logic             ld_hit, inj_hit, upd_en;

    assign ld_hit  = ld_we_i  && (ld_idx_i  == IDX_W'(g));
    assign inj_hit = inj_en_i && (inj_idx_i == IDX_W'(g));
    assign upd_en  = ld_hit || inj_hit;

    // Next state: a load write overrides an injected flip on the same pair.
    always_comb begin
      val_d = val_q;
      shd_d = shd_q;
      if (ld_hit) begin
        if (ld_to_shadow_i) shd_d = ld_data_i;
        else                val_d = ld_data_i;
      end else if (inj_hit) begin
        if (inj_to_shadow_i) shd_d = shd_q ^ flip_mask;
        else                 val_d = val_q ^ flip_mask;
      end
    end

    // Reset leaves every pair consistent: all zeros against all ones.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        shd_q <= '1;
      end else if (upd_en) begin
        val_q <= val_d;
        shd_q <= shd_d;
      end
    end

    // A pair is healthy only when every bit differs from its shadow bit.
    assign pair_bad[g] = ~&(val_q ^ shd_q);
  end

  assign mismatch_o = |pair_bad;

  // R11 / R2 / R3: flipping one bit of a healthy bank must break a pair.
  a_r11_flip_breaks_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en_i && !ld_we_i && !mismatch_o) |=> mismatch_o);

  // R1: a healthy bank that nobody touches stays healthy.
  a_r1_idle_stays_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (!mismatch_o && !ld_we_i && !inj_en_i) |=> !mismatch_o);

endmodule

// File: rtl/cfgshd_seq.sv
module cfgshd_seq
  import cfgshd_pkg::*;
#(
  parameter int  PULSE_CYC = 4,
  localparam int CNT_W     = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1,
  localparam int RUN_W     = $clog2(PULSE_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch_i,
  input  logic ld_busy_i,
  input  logic warm_rst_i,
  input  logic sw_wr_i,
  input  logic sw_wdata_i,
  output logic rst_req_o,
  output logic flag_n_o
);

  mon_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mis_q, mis_d;
  logic             flag_n_q, flag_n_d, flag_en;
  logic             armed, fire, sw_set;

  // Compare stage: registered once, masked unless armed and not loading.
  assign armed = (state_q == ST_ARMED) && !ld_busy_i;
  assign mis_d = !warm_rst_i && armed && mismatch_i;

  assign fire   = (state_q == ST_ARMED) && mis_q && !warm_rst_i;
  assign sw_set = sw_wr_i && sw_wdata_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (warm_rst_i) begin
      state_d = ST_WAIT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ARMED: if (mis_q) begin
          state_d = ST_PULSE;
          cnt_d   = CNT_W'(PULSE_CYC - 1);
        end
        ST_PULSE: begin
          if (cnt_q == '0) state_d = ST_WAIT;
          else             cnt_d   = cnt_q - CNT_W'(1);
        end
        ST_WAIT:  if (ld_busy_i)  state_d = ST_LOAD;
        ST_LOAD:  if (!ld_busy_i) state_d = ST_ARMED;
        default:  state_d = ST_WAIT;
      endcase
    end
  end

  // Flag: software may only set it, the event only clears it, event wins.
  always_comb begin
    flag_n_d = flag_n_q;
    if (sw_set) flag_n_d = 1'b1;
    if (fire)   flag_n_d = 1'b0;
  end
  assign flag_en = sw_set || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mis_q   <= mis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_n_q <= 1'b1;
    else if (flag_en) flag_n_q <= flag_n_d;
  end

  assign rst_req_o = (state_q == ST_PULSE);
  assign flag_n_o  = flag_n_q;

  // Run-length counter of the request, used only by the checks below.
  logic [RUN_W-1:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run_q <= '0;
    else if (rst_req_o) hi_run_q <= hi_run_q + RUN_W'(1);
    else                hi_run_q <= '0;
  end

  // R4: an unaborted pulse lasts exactly PULSE_CYC cycles.
  a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_req_o) && !$past(warm_rst_i)) |-> (hi_run_q == RUN_W'(PULSE_CYC)));

  // R4: the request never runs past PULSE_CYC cycles.
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (hi_run_q < RUN_W'(PULSE_CYC)));

  // R5: the flag is low whenever a request starts.
  a_r5_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> !flag_n_o);

  // R7: a warm reset leaves the flag alone.
  a_r7_warm_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst_i && !sw_set) |=> $stable(flag_n_o));

  // R8: a busy load never lets the compare stage latch a mismatch.
  a_r8_busy_masks: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy_i |=> !mis_q);

  // R6: a software set outside the armed state always lands.
  a_r6_sw_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && (state_q != ST_ARMED)) |=> flag_n_o);

endmodule

// File: rtl/cfgshd_monitor.sv
module cfgshd_monitor #(
  parameter int  NUM_REGS   = 4,
  parameter int  REG_W      = 16,
  parameter int  PULSE_CYC  = 4,
  parameter int  SYNC_STAGE = 2,
  localparam int IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int BIT_W      = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             warm_rst,
  input  logic             ld_busy,
  input  logic             ld_we,
  input  logic             ld_to_shadow,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [REG_W-1:0] ld_data,
  input  logic             inj_en,
  input  logic             inj_to_shadow,
  input  logic [IDX_W-1:0] inj_idx,
  input  logic [BIT_W-1:0] inj_bit,
  input  logic             sw_wr,
  input  logic             sw_wdata,
  output logic             rst_req,
  output logic             flag_n
);

  logic rst_n;
  logic mismatch;

  cfgshd_rst_sync #(.STAGES(SYNC_STAGE)) u_rst_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (rst_n)
  );

  cfgshd_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
    .clk             (clk),
    .rst_n           (rst_n),
    .ld_we_i         (ld_we),
    .ld_to_shadow_i  (ld_to_shadow),
    .ld_idx_i        (ld_idx),
    .ld_data_i       (ld_data),
    .inj_en_i        (inj_en),
    .inj_to_shadow_i (inj_to_shadow),
    .inj_idx_i       (inj_idx),
    .inj_bit_i       (inj_bit),
    .mismatch_o      (mismatch)
  );

  cfgshd_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mismatch_i (mismatch),
    .ld_busy_i  (ld_busy),
    .warm_rst_i (warm_rst),
    .sw_wr_i    (sw_wr),
    .sw_wdata_i (sw_wdata),
    .rst_req_o  (rst_req),
    .flag_n_o   (flag_n)
  );

endmodule

// File: tb/cfgshd_monitor_bench.sv
module cfgshd_monitor_bench;

  localparam int NREG  = 4;
  localparam int RW    = 16;
  localparam int PULSE = 4;
  localparam int IW    = 2;
  localparam int BW    = 4;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          warm_rst = 1'b0;
  logic          ld_busy = 1'b0;
  logic          ld_we = 1'b0;
  logic          ld_to_shadow = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [RW-1:0] ld_data = '0;
  logic          inj_en = 1'b0;
  logic          inj_to_shadow = 1'b0;
  logic [IW-1:0] inj_idx = '0;
  logic [BW-1:0] inj_bit = '0;
  logic          sw_wr = 1'b0;
  logic          sw_wdata = 1'b0;
  logic          rst_req;
  logic          flag_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cfgshd_monitor u_cfgshd_monitor (
    .clk (clk), .por_n (por_n), .warm_rst (warm_rst), .ld_busy (ld_busy),
    .ld_we (ld_we), .ld_to_shadow (ld_to_shadow), .ld_idx (ld_idx),
    .ld_data (ld_data), .inj_en (inj_en), .inj_to_shadow (inj_to_shadow),
    .inj_idx (inj_idx), .inj_bit (inj_bit), .sw_wr (sw_wr),
    .sw_wdata (sw_wdata), .rst_req (rst_req), .flag_n (flag_n)
  );

  // ---------------- behavioural reference model ----------------
  logic [RW-1:0] m_val [NREG];
  logic [RW-1:0] m_shd [NREG];
  int   m_mode = 2;        // 0 armed, 1 pulsing, 2 awaiting reload, 3 reloading
  int   m_left = 0;
  bit   m_seen = 1'b0;
  bit   m_flag = 1'b1;
  int   since_por = 0;
  bit   model_on = 1'b0;

  always @(posedge clk) begin
    bit broken, seen_next, fire;
    if (!por_n) since_por = 0;
    else if (since_por < 10) since_por++;
    if (since_por <= 2) begin
      for (int i = 0; i < NREG; i++) begin m_val[i] = '0; m_shd[i] = '1; end
      m_mode = 2; m_left = 0; m_seen = 1'b0; m_flag = 1'b1;
    end else begin
      broken = 1'b0;
      for (int i = 0; i < NREG; i++) if ((m_val[i] ^ m_shd[i]) != '1) broken = 1'b1;
      seen_next = !warm_rst && m_mode == 0 && !ld_busy && broken;
      fire = m_mode == 0 && m_seen && !warm_rst;
      if (sw_wr && sw_wdata) m_flag = 1'b1;
      if (fire) m_flag = 1'b0;
      if (warm_rst) begin m_mode = 2; m_left = 0; end
      else case (m_mode)
        0: if (m_seen) begin m_mode = 1; m_left = PULSE - 1; end
        1: if (m_left == 0) m_mode = 2; else m_left--;
        2: if (ld_busy) m_mode = 3;
        default: if (!ld_busy) m_mode = 0;
      endcase
      m_seen = seen_next;
      if (ld_we) begin
        if (ld_to_shadow) m_shd[ld_idx] = ld_data; else m_val[ld_idx] = ld_data;
      end else if (inj_en) begin
        if (inj_to_shadow) m_shd[inj_idx][inj_bit] = ~m_shd[inj_idx][inj_bit];
        else               m_val[inj_idx][inj_bit] = ~m_val[inj_idx][inj_bit];
      end
    end
    model_on = 1'b1;
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model (R4 pulse shape, R5 flag).
  always @(negedge clk) begin
    if (model_on) begin
      chk("R4 model rst_req", rst_req, logic'(m_mode == 1));
      chk("R5 model flag_n", flag_n, m_flag);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [RW-1:0] pat(int i);
    return RW'(16'hA5C3 ^ (i * 16'h1357));
  endfunction

  task automatic reload();
    ld_busy = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      for (int s = 0; s < 2; s++) begin
        ld_we = 1'b1; ld_idx = IW'(i); ld_to_shadow = s[0];
        ld_data = s[0] ? ~pat(i) : pat(i);
        tick(1);
      end
    end
    ld_we = 1'b0; ld_busy = 1'b0;
    tick(3);
  endtask

  task automatic inject(bit to_shd, int idx, int bitpos);
    inj_en = 1'b1; inj_to_shadow = to_shd; inj_idx = IW'(idx); inj_bit = BW'(bitpos);
    tick(1);
    inj_en = 1'b0;
  endtask

  task automatic sw_write(bit v);
    sw_wr = 1'b1; sw_wdata = v;
    tick(1);
    sw_wr = 1'b0; sw_wdata = 1'b0;
  endtask

  task automatic pulse_warm();
    warm_rst = 1'b1;
    tick(1);
    warm_rst = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    por_n = 1'b1;
    tick(4);
    chk("R10 rst_req after por", rst_req, 1'b0);
    chk("R10 flag_n after por", flag_n, 1'b1);

    // R9: before any reload, a broken pair is ignored.
    inject(1'b0, 1, 3);
    tick(8);
    chk("R9 disarmed after por", rst_req, 1'b0);

    reload();
    tick(5);
    chk("R1 clean bank quiet", rst_req, 1'b0);

    // R8: break a pair while loading, repair it before busy drops.
    ld_busy = 1'b1; ld_we = 1'b1; ld_idx = 0; ld_to_shadow = 1'b0; ld_data = 16'h1234;
    tick(1);
    ld_we = 1'b0;
    tick(6);
    chk("R8 masked during load", rst_req, 1'b0);
    ld_we = 1'b1; ld_to_shadow = 1'b1; ld_data = ~16'h1234;
    tick(1);
    ld_we = 1'b0; ld_busy = 1'b0;
    tick(4);
    chk("R8 quiet after load", rst_req, 1'b0);

    // R2: flip top bit of the last register.
    inject(1'b0, 3, 15);
    chk("R2 no req at +1", rst_req, 1'b0);
    tick(1);
    chk("R2 no req at +2", rst_req, 1'b0);
    tick(1);
    chk("R2 req rises", rst_req, 1'b1);
    chk("R5 flag low with req", flag_n, 1'b0);
    tick(3);
    chk("R4 last pulse cycle", rst_req, 1'b1);
    tick(1);
    chk("R4 pulse ends", rst_req, 1'b0);
    tick(10);
    chk("R9 no retrigger before reload", rst_req, 1'b0);

    sw_write(1'b0);
    chk("R6 write 0 ignored", flag_n, 1'b0);
    sw_write(1'b1);
    chk("R6 write 1 sets", flag_n, 1'b1);

    reload();
    // R3: flip bottom bit of the first shadow word.
    inject(1'b1, 0, 0);
    tick(2);
    chk("R3 shadow flip req", rst_req, 1'b1);
    tick(6);

    // R7: warm reset with flag at 0, then a mismatch without reload.
    pulse_warm();
    chk("R7 warm keeps flag 0", flag_n, 1'b0);
    inject(1'b0, 2, 7);
    tick(8);
    chk("R7 disarmed after warm", rst_req, 1'b0);
    reload();
    sw_write(1'b1);
    pulse_warm();
    chk("R7 warm keeps flag 1", flag_n, 1'b1);
    reload();

    // R11: load write outside a reload breaks a pair.
    ld_we = 1'b1; ld_idx = 1; ld_to_shadow = 1'b0; ld_data = 16'h0F0F;
    tick(1);
    ld_we = 1'b0;
    tick(2);
    chk("R11 stray write req", rst_req, 1'b1);
    tick(6);
    reload();
    sw_write(1'b1);

    // R6: set in the same cycle as the event, event wins.
    inject(1'b1, 2, 9);
    tick(1);
    sw_wr = 1'b1; sw_wdata = 1'b1;
    tick(1);
    sw_wr = 1'b0; sw_wdata = 1'b0;
    chk("R6 event beats set", flag_n, 1'b0);
    chk("R2 req with clash", rst_req, 1'b1);
    tick(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule